// File: doc/BRIEF.md
# Two-Port Hardware Semaphore Unit

This unit holds a small bank of single-bit tokens that two independent agents, the left port and the right port, use to agree on who may touch a shared resource. An example of such a resource is a region of a dual-port memory placed beside the unit. An agent asks for a token by writing a zero to it and gives it back by writing a one. Reading a token tells that agent whether it is the holder. Only one side can hold a given token at any time.

Each side has its own request latch per token, and both latches feed one shared ownership record. If an agent asks while the other side holds the token, its request stays pending. When the holder lets go, the token passes directly to the waiting side without any further write. When both sides ask for a free token in the same clock, a per-token alternating priority bit picks the winner. The whole unit runs on one clock. Read data and the error flag are registered outputs. Read data uses plain strobes with no back-pressure: the result is present for exactly one cycle, and a consumer that cannot take it in that cycle must issue the read again.

Top module: `dual_sema_unit`

## Requirements
- R1: The token used by an access is chosen by the port's 3-bit address, giving eight tokens. An access to one token never changes the state seen on any other token.
- R2: A port makes a token access only in a cycle where its chip enable is high (inactive) and its token select is low (active). If chip enable and token select are both low, the port's error output goes high in the next cycle for one cycle, and no token state changes. All other combinations have no effect and leave the error output low.
- R3: A write is a token access with the read/write line low. Only data bit 0 is used: 0 records a request in that port's latch and 1 records a release. Data bits 7 to 1 are ignored.
- R4: A read is a token access with the read/write line high. One cycle after the read, all eight read-data bits equal the reader's status as it was before any write in the read cycle. The status is 0 when the reader holds the token and 1 otherwise, so a free token reads 1 on both sides. The read-valid output is high in that cycle only if output enable was low in the read cycle. Read data keeps its value until the next read.
- R5: If a port requests a free token while the other side does not, that port takes the token. It keeps the token, whatever the other side writes, until it writes a release.
- R6: If the other side's latch holds a request at the moment the holder releases, that side takes the token in the same cycle. It then holds the token until it releases.
- R7: If both ports request a free token in the same cycle, exactly one side takes it. After reset the left side wins the first such tie. Each tie on a token flips that token's priority, so wins alternate.
- R8: A release written by a port that does not hold the token only clears its own request. Ownership does not change. A request cancelled this way is not granted when the holder later releases.
- R9: A synchronous active-high reset sets every request latch to release, frees every token, gives every token's priority to the left side, sets read data to all ones and lowers read-valid and error.
- R10: The two sides never both hold the same token. If both read the same token in one cycle, the two read results are not both zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock shared by both ports |
| rst | input | 1 | Synchronous reset, active high |
| l_ce_n | input | 1 | Left chip enable, active low; must be high for a token access |
| l_sem_n | input | 1 | Left token select, active low |
| l_rw_n | input | 1 | Left direction: 1 read, 0 write |
| l_oe_n | input | 1 | Left output enable, active low; gates read-valid |
| l_addr | input | 3 | Left token address |
| l_wdata | input | 8 | Left write data; bit 0 used |
| l_rdata | output | 8 | Left registered read data |
| l_rvalid | output | 1 | Left read-data valid strobe |
| l_err | output | 1 | Left illegal-select flag |
| r_ce_n | input | 1 | Right chip enable, active low |
| r_sem_n | input | 1 | Right token select, active low |
| r_rw_n | input | 1 | Right direction: 1 read, 0 write |
| r_oe_n | input | 1 | Right output enable, active low |
| r_addr | input | 3 | Right token address |
| r_wdata | input | 8 | Right write data; bit 0 used |
| r_rdata | output | 8 | Right registered read data |
| r_rvalid | output | 1 | Right read-data valid strobe |
| r_err | output | 1 | Right illegal-select flag |

## Verification
The arbitration is driven first through a long sequence on single tokens. It covers uncontested requests from each side, a request against a holder, release with and without a waiting request, and releases from the non-holder. This separates a working handover from one where the token only frees or stays put. Repeated same-cycle requests show whether the tie winner alternates or is fixed. A token at a second address, write data with the upper bits set opposite to bit 0, and illegal or memory-only select codes show whether accesses leak between tokens or through unused inputs. A read that coincides with a handover shows whether read data reflects the state before or after the update.

// File: rtl/sema_pkg.sv
package sema_pkg;
  typedef enum logic [1:0] {
    OWN_NONE  = 2'd0,
    OWN_LEFT  = 2'd1,
    OWN_RIGHT = 2'd2
  } owner_e;

  typedef struct packed {
    logic rd;
    logic wr;
    logic bad;
  } port_req_t;
endpackage

// File: rtl/sema_port_dec.sv
module sema_port_dec
  import sema_pkg::*;
#(
  parameter int SEM_AW = 3,
  parameter int DATA_W = 8,
  localparam int NUM_SEM = 1 << SEM_AW
) (
  input  logic              ce_n,
  input  logic              sem_n,
  input  logic              rw_n,
  input  logic [SEM_AW-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output port_req_t         req,
  output logic [NUM_SEM-1:0] wsel,
  output logic              wbit
);
  logic tok_acc;

  always_comb begin
    tok_acc = ce_n & ~sem_n;
    req.rd  = tok_acc & rw_n;
    req.wr  = tok_acc & ~rw_n;
    req.bad = ~ce_n & ~sem_n;
    wbit    = wdata[0];
  end

  for (genvar i = 0; i < NUM_SEM; i++) begin : g_wsel
    assign wsel[i] = req.wr && (addr == SEM_AW'(i));
  end
endmodule

// File: rtl/sema_cell.sv
module sema_cell
  import sema_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic wr_l,
  input  logic d_l,
  input  logic wr_r,
  input  logic d_r,
  output logic stat_l,
  output logic stat_r
);
  logic   lat_l, lat_r, lat_l_nx, lat_r_nx;
  logic   prio, prio_nx;
  owner_e owner, owner_nx;

  always_comb begin
    lat_l_nx = wr_l ? d_l : lat_l;
    lat_r_nx = wr_r ? d_r : lat_r;
    owner_nx = owner;
    prio_nx  = prio;
    unique case (owner)
      OWN_LEFT: begin
        if (lat_l_nx) owner_nx = lat_r_nx ? OWN_NONE : OWN_RIGHT;
      end
      OWN_RIGHT: begin
        if (lat_r_nx) owner_nx = lat_l_nx ? OWN_NONE : OWN_LEFT;
      end
      default: begin
        if (!lat_l_nx && !lat_r_nx) begin
          owner_nx = prio ? OWN_RIGHT : OWN_LEFT;
          prio_nx  = ~prio;
        end else if (!lat_l_nx) begin
          owner_nx = OWN_LEFT;
        end else if (!lat_r_nx) begin
          owner_nx = OWN_RIGHT;
        end
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      lat_l <= 1'b1;
      lat_r <= 1'b1;
      prio  <= 1'b0;
      owner <= OWN_NONE;
    end else begin
      lat_l <= lat_l_nx;
      lat_r <= lat_r_nx;
      prio  <= prio_nx;
      owner <= owner_nx;
    end
  end

  assign stat_l = (owner != OWN_LEFT);
  assign stat_r = (owner != OWN_RIGHT);
endmodule

// File: rtl/sema_rd_port.sv
module sema_rd_port
  import sema_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  port_req_t         req,
  input  logic              oe_n,
  input  logic              stat,
  output logic [DATA_W-1:0] rdata,
  output logic              rvalid,
  output logic              err
);
  always_ff @(posedge clk) begin
    if (rst) begin
      rdata  <= '1;
      rvalid <= 1'b0;
      err    <= 1'b0;
    end else begin
      if (req.rd) rdata <= {DATA_W{stat}};
      rvalid <= req.rd & ~oe_n;
      err    <= req.bad;
    end
  end
endmodule

// File: rtl/dual_sema_unit.sv
module dual_sema_unit
  import sema_pkg::*;
#(
  parameter int SEM_AW = 3,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              l_ce_n,
  input  logic              l_sem_n,
  input  logic              l_rw_n,
  input  logic              l_oe_n,
  input  logic [SEM_AW-1:0] l_addr,
  input  logic [DATA_W-1:0] l_wdata,
  output logic [DATA_W-1:0] l_rdata,
  output logic              l_rvalid,
  output logic              l_err,
  input  logic              r_ce_n,
  input  logic              r_sem_n,
  input  logic              r_rw_n,
  input  logic              r_oe_n,
  input  logic [SEM_AW-1:0] r_addr,
  input  logic [DATA_W-1:0] r_wdata,
  output logic [DATA_W-1:0] r_rdata,
  output logic              r_rvalid,
  output logic              r_err
);
  localparam int NUM_SEM = 1 << SEM_AW;

  port_req_t          req_l, req_r;
  logic [NUM_SEM-1:0] wsel_l, wsel_r;
  logic               wbit_l, wbit_r;
  logic [NUM_SEM-1:0] stat_l_vec, stat_r_vec;

  sema_port_dec #(.SEM_AW(SEM_AW), .DATA_W(DATA_W)) u_dec_l (
    .ce_n(l_ce_n), .sem_n(l_sem_n), .rw_n(l_rw_n), .addr(l_addr),
    .wdata(l_wdata), .req(req_l), .wsel(wsel_l), .wbit(wbit_l)
  );

  sema_port_dec #(.SEM_AW(SEM_AW), .DATA_W(DATA_W)) u_dec_r (
    .ce_n(r_ce_n), .sem_n(r_sem_n), .rw_n(r_rw_n), .addr(r_addr),
    .wdata(r_wdata), .req(req_r), .wsel(wsel_r), .wbit(wbit_r)
  );

  for (genvar i = 0; i < NUM_SEM; i++) begin : g_cell
    sema_cell u_cell (
      .clk(clk), .rst(rst),
      .wr_l(wsel_l[i]), .d_l(wbit_l),
      .wr_r(wsel_r[i]), .d_r(wbit_r),
      .stat_l(stat_l_vec[i]), .stat_r(stat_r_vec[i])
    );
  end

  sema_rd_port #(.DATA_W(DATA_W)) u_rd_l (
    .clk(clk), .rst(rst), .req(req_l), .oe_n(l_oe_n),
    .stat(stat_l_vec[l_addr]),
    .rdata(l_rdata), .rvalid(l_rvalid), .err(l_err)
  );

  sema_rd_port #(.DATA_W(DATA_W)) u_rd_r (
    .clk(clk), .rst(rst), .req(req_r), .oe_n(r_oe_n),
    .stat(stat_r_vec[r_addr]),
    .rdata(r_rdata), .rvalid(r_rvalid), .err(r_err)
  );
endmodule

// File: rtl/sema_chk.sv
module sema_chk #(
  parameter int SEM_AW = 3,
  parameter int DATA_W = 8,
  localparam int NUM_SEM = 1 << SEM_AW
) (
  input logic               clk,
  input logic               rst,
  input logic               l_ce_n,
  input logic               l_sem_n,
  input logic               l_rw_n,
  input logic               l_oe_n,
  input logic [SEM_AW-1:0]  l_addr,
  input logic [DATA_W-1:0]  l_wdata,
  input logic [DATA_W-1:0]  l_rdata,
  input logic               l_rvalid,
  input logic               l_err,
  input logic               r_ce_n,
  input logic               r_sem_n,
  input logic               r_rw_n,
  input logic [SEM_AW-1:0]  r_addr,
  input logic [DATA_W-1:0]  r_rdata,
  input logic [NUM_SEM-1:0] stat_l_vec,
  input logic [NUM_SEM-1:0] stat_r_vec
);
  logic l_rd, r_rd;
  assign l_rd = l_ce_n && !l_sem_n && l_rw_n;
  assign r_rd = r_ce_n && !r_sem_n && r_rw_n;

  a_r2_err_raised: assert property (@(posedge clk) disable iff (rst)
    (!l_ce_n && !l_sem_n) |=> l_err);

  a_r2_err_quiet: assert property (@(posedge clk) disable iff (rst)
    (l_ce_n || l_sem_n) |=> !l_err);

  a_r4_valid_on: assert property (@(posedge clk) disable iff (rst)
    (l_rd && !l_oe_n) |=> l_rvalid);

  a_r4_valid_off: assert property (@(posedge clk) disable iff (rst)
    !(l_rd && !l_oe_n) |=> !l_rvalid);

  a_r4_uniform_byte: assert property (@(posedge clk) disable iff (rst)
    l_rvalid |-> (l_rdata == '0 || l_rdata == '1));

  a_r10_not_both: assert property (@(posedge clk) disable iff (rst)
    (l_rd && r_rd && l_addr == r_addr) |=> !(l_rdata == '0 && r_rdata == '0));

  a_r9_reset_free: assert property (@(posedge clk)
    rst |=> (stat_l_vec == '1 && stat_r_vec == '1));

  for (genvar i = 0; i < NUM_SEM; i++) begin : g_hold
    logic l_rel;
    assign l_rel = l_ce_n && !l_sem_n && !l_rw_n &&
                   (l_addr == SEM_AW'(i)) && l_wdata[0];
    a_r5_holder_keeps: assert property (@(posedge clk) disable iff (rst)
      (!stat_l_vec[i] && !l_rel) |=> !stat_l_vec[i]);
  end
endmodule

bind dual_sema_unit sema_chk #(.SEM_AW(SEM_AW), .DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst(rst),
  .l_ce_n(l_ce_n), .l_sem_n(l_sem_n), .l_rw_n(l_rw_n), .l_oe_n(l_oe_n),
  .l_addr(l_addr), .l_wdata(l_wdata), .l_rdata(l_rdata),
  .l_rvalid(l_rvalid), .l_err(l_err),
  .r_ce_n(r_ce_n), .r_sem_n(r_sem_n), .r_rw_n(r_rw_n),
  .r_addr(r_addr), .r_rdata(r_rdata),
  .stat_l_vec(stat_l_vec), .stat_r_vec(stat_r_vec)
);

// File: tb/sim_dual_sema_unit.sv
`timescale 1ns/1ps
module sim_dual_sema_unit;
  logic       clk = 1'b0;
  logic       rst;
  logic       l_ce_n, l_sem_n, l_rw_n, l_oe_n;
  logic [2:0] l_addr;
  logic [7:0] l_wdata, l_rdata;
  logic       l_rvalid, l_err;
  logic       r_ce_n, r_sem_n, r_rw_n, r_oe_n;
  logic [2:0] r_addr;
  logic [7:0] r_wdata, r_rdata;
  logic       r_rvalid, r_err;

  int compared = 0;
  int mismatched = 0;

  always #5 clk = ~clk;

  dual_sema_unit u0 (
    .clk(clk), .rst(rst),
    .l_ce_n(l_ce_n), .l_sem_n(l_sem_n), .l_rw_n(l_rw_n), .l_oe_n(l_oe_n),
    .l_addr(l_addr), .l_wdata(l_wdata), .l_rdata(l_rdata),
    .l_rvalid(l_rvalid), .l_err(l_err),
    .r_ce_n(r_ce_n), .r_sem_n(r_sem_n), .r_rw_n(r_rw_n), .r_oe_n(r_oe_n),
    .r_addr(r_addr), .r_wdata(r_wdata), .r_rdata(r_rdata),
    .r_rvalid(r_rvalid), .r_err(r_err)
  );

  // {addr[2:0], l_wr, l_bit, r_wr, r_bit, exp_l, exp_r}
  localparam logic [8:0] VEC [23] = '{
    9'b010_0_0_0_0_1_1, // R9 idle: free
    9'b010_1_0_0_0_0_1, // R5 left requests
    9'b010_0_0_1_0_0_1, // R5 right asks, left keeps
    9'b010_1_1_0_0_1_0, // R6 left releases, right takes
    9'b010_1_0_0_0_1_0, // R5 left asks, right keeps
    9'b010_0_0_1_1_0_1, // R6 right releases, left takes
    9'b010_1_1_0_0_1_1, // R5 free
    9'b010_0_0_1_0_1_0, // R5 right requests
    9'b010_0_0_1_1_1_1, // R5 free
    9'b010_1_0_0_0_0_1, // R5 left requests
    9'b010_1_1_0_0_1_1, // R5 free
    9'b010_1_0_1_0_0_1, // R7 tie, left wins
    9'b010_1_1_1_1_1_1, // R7 both release
    9'b010_1_0_1_0_1_0, // R7 tie, right wins
    9'b010_1_1_1_1_1_1, // R7 both release
    9'b010_1_0_1_0_0_1, // R7 tie, left wins again
    9'b010_1_1_1_1_1_1, // R7 both release
    9'b010_1_0_0_0_0_1, // R8 left requests
    9'b010_0_0_1_1_0_1, // R8 right releases while not holder
    9'b010_0_0_1_0_0_1, // R8 right asks
    9'b010_0_0_1_1_0_1, // R8 right cancels
    9'b010_1_1_0_0_1_1, // R8 left releases, token free
    9'b101_1_0_0_0_0_1  // R1 left takes token 5
  };

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic set_idle();
    l_ce_n = 1; l_sem_n = 1; l_rw_n = 1; l_oe_n = 1; l_addr = 0; l_wdata = 0;
    r_ce_n = 1; r_sem_n = 1; r_rw_n = 1; r_oe_n = 1; r_addr = 0; r_wdata = 0;
  endtask

  task automatic wr_pair(logic [2:0] a, logic lw, logic ld, logic rw, logic rd);
    @(negedge clk);
    set_idle();
    if (lw) begin
      l_sem_n = 0; l_rw_n = 0; l_addr = a; l_wdata = {7'h55, ld};
    end
    if (rw) begin
      r_sem_n = 0; r_rw_n = 0; r_addr = a; r_wdata = {7'h2a, rd};
    end
  endtask

  task automatic rd_both(string tag, logic [2:0] a, logic el, logic er);
    @(negedge clk);
    set_idle();
    l_sem_n = 0; l_oe_n = 0; l_addr = a;
    r_sem_n = 0; r_oe_n = 0; r_addr = a;
    @(negedge clk);
    set_idle();
    chk({tag, " left status"}, 32'(l_rdata), 32'({8{el}}));
    chk({tag, " right status"}, 32'(r_rdata), 32'({8{er}}));
    chk({tag, " left rvalid"}, 32'(l_rvalid), 32'd1);
  endtask

  initial begin
    #2_000_000;
    mismatched++;
    $display("FAIL watchdog actual=running expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    set_idle();
    rst = 1;
    repeat (3) @(negedge clk);
    rst = 0;
    chk("R9 reset rdata", 32'(l_rdata), 32'hff);
    chk("R9 reset rvalid", 32'(l_rvalid), 32'd0);
    chk("R9 reset err", 32'(r_err), 32'd0);

    foreach (VEC[i]) begin
      logic [8:0] v;
      v = VEC[i];
      wr_pair(v[8:6], v[5], v[4], v[3], v[2]);
      rd_both($sformatf("vector %0d", i), v[8:6], v[1], v[0]);
    end

    // R1: token 2 untouched by token 5 traffic
    rd_both("R1 token2 free", 3'd2, 1, 1);
    rd_both("R1 token5 held", 3'd5, 0, 1);

    // R3: upper data bits ignored
    @(negedge clk); set_idle();
    r_sem_n = 0; r_rw_n = 0; r_addr = 3'd3; r_wdata = 8'hfe;
    rd_both("R3 bit0 zero requests", 3'd3, 1, 0);
    @(negedge clk); set_idle();
    r_sem_n = 0; r_rw_n = 0; r_addr = 3'd3; r_wdata = 8'h01;
    rd_both("R3 bit0 one releases", 3'd3, 1, 1);

    // R2: illegal select raises error, no state change
    @(negedge clk); set_idle();
    l_ce_n = 0; l_sem_n = 0; l_rw_n = 0; l_addr = 3'd3; l_wdata = 8'h00;
    @(negedge clk); set_idle();
    chk("R2 err raised", 32'(l_err), 32'd1);
    @(negedge clk);
    chk("R2 err one cycle", 32'(l_err), 32'd0);
    rd_both("R2 illegal write ignored", 3'd3, 1, 1);
    @(negedge clk); set_idle();
    l_ce_n = 0; l_sem_n = 1; l_rw_n = 0; l_addr = 3'd3; l_wdata = 8'h00;
    @(negedge clk); set_idle();
    chk("R2 memory access no err", 32'(l_err), 32'd0);
    rd_both("R2 memory access ignored", 3'd3, 1, 1);

    // R4: output enable high suppresses valid, data still updates
    @(negedge clk); set_idle();
    l_sem_n = 0; l_addr = 3'd5;
    @(negedge clk); set_idle();
    chk("R4 oe high rvalid", 32'(l_rvalid), 32'd0);
    chk("R4 oe high rdata", 32'(l_rdata), 32'h00);
    @(negedge clk);
    chk("R4 rdata holds", 32'(l_rdata), 32'h00);

    // R4/R6: read sees state before same-cycle handover
    wr_pair(3'd7, 1, 0, 0, 0);
    wr_pair(3'd7, 0, 0, 1, 0);
    @(negedge clk); set_idle();
    l_sem_n = 0; l_rw_n = 0; l_addr = 3'd7; l_wdata = 8'h01;
    r_sem_n = 0; r_oe_n = 0; r_addr = 3'd7;
    @(negedge clk); set_idle();
    chk("R4 read before handover", 32'(r_rdata), 32'hff);
    rd_both("R6 handover done", 3'd7, 1, 0);

    // R9: reset mid-run frees tokens and restores left priority
    @(negedge clk); set_idle();
    rst = 1;
    repeat (2) @(negedge clk);
    chk("R9 rvalid in reset", 32'(r_rvalid), 32'd0);
    rst = 0;
    rd_both("R9 token5 freed", 3'd5, 1, 1);
    rd_both("R9 token7 freed", 3'd7, 1, 1);
    wr_pair(3'd2, 1, 0, 1, 0);
    rd_both("R7 R9 tie after reset left wins", 3'd2, 0, 1);
    rd_both("R10 token2 one holder", 3'd2, 0, 1);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule